// File: doc/BRIEF.md
# Dual-slot hot-plug fault supervisor

This block is the digital sequencer and protection logic for a controller that powers two add-in card slots. For each slot it switches a main rail pair and an auxiliary rail. It watches comparator flags from the analog front end: a current-regulation level flag, a hard-short level flag, undervoltage flags for the main and auxiliary inputs, and an over-temperature flag. When a slot misbehaves, the block shuts the offending rail off and latches a fault. Analog sensing, gate drive and the serial management link lie outside the block. The link reaches the block through a small parallel register port.

Overcurrent is handled on two levels. A moderate overload is tolerated for a programmable number of clock cycles before the main rail trips. A hard short trips it on the next clock edge.

A latched fault is released by withdrawing the enable of the rail that faulted. When both rails of a slot faulted, both enables must be withdrawn before the slot's fault output clears.

A per-slot diagnostic override forces all rails of that slot on and defeats the protections. While it is active, the slot's fault and power-good outputs stay released, but the sticky status bits still record what happened.

After the standby supply becomes valid, a power-on timer keeps every output off and every register clear.

Top module: `hotplug_supervisor`

## Requirements
- R1: While `standbyOk` is low, and for `PorCycles` clock edges after it rises, the outputs are held inactive: `mainEn` and `auxEn` are 0, and `faultN`, `pwrGdN` and `intN` are 1. During this time every register reads 0 and writes are ignored. A low level on `standbyOk` restarts the timer.
- R2: Outside the override, `mainEn[s]` is 1 exactly when three conditions hold: the slot is requested (`onN[s]` low or control bit `s` set), no main fault is latched, and `mainUv[s]` is low. `pwrGdN[s]` is low exactly when `mainEn[s]` is 1 and `mainUv[s]` is low.
- R3: If `senseRegHit[s]` is sampled high with the main rail on for D+1 consecutive edges, where D is the duration register at address 3, the main fault latches at that edge and `mainEn[s]` drops. A single low sample restarts the count.
- R4: If `senseShortHit[s]` is sampled high with the main rail on, the main fault latches at that edge and `mainEn[s]` drops.
- R5: If `mainUv[s]` is sampled high while slot `s` is requested, the main fault latches.
- R6: If `overTemp[s]` is sampled high with the auxiliary rail on, the auxiliary fault latches and `auxEn[s]` drops.
- R7: `faultN[s]` is low while either fault of the slot is latched. The main fault clears at the first edge at which the main request is absent. The auxiliary fault clears at the first edge at which the auxiliary request is absent. If both faults are latched, both requests must be withdrawn.
- R8: `auxEn[s]` is 1 exactly when three conditions hold: the slot is requested for aux (`auxEnN[s]` low or control bit 2+s set), no aux fault is latched, and `auxUv[s]` is low. `mainUv` has no effect on it.
- R9: When `forceOnN[s]` is low after power-on reset, `mainEn[s]` is 1 and `auxEn[s]` is the inverse of `auxUv[s]`. No fault latches for the slot, and `faultN[s]` and `pwrGdN[s]` read 1. Status bits still set from the events.
- R10: Control bit 4+s set makes `forceOnN[s]` have no effect.
- R11: Status register (address 1) holds sticky bits: overcurrent in bits 1:0, main undervoltage in bits 3:2 and over-temperature in bits 5:4. Writing 1 to a bit clears it, writing 0 leaves it. An event in the same cycle as the clearing write wins.
- R12: `intN` is low while any status bit is set and control bit 6 (interrupt mask) is 0.
- R13: Address 0 reads back the control register (bits 6:0). Address 2 reads `{auxEn, mainEn}` in bits 3:0. Address 3 is the read/write regulation duration D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| standbyOk | input | 1 | Standby supply valid; low resets the block asynchronously |
| senseRegHit | input | 2 | Per slot: main sense above the regulation level |
| senseShortHit | input | 2 | Per slot: main sense above the hard-short level |
| mainUv | input | 2 | Per slot: main input undervoltage |
| auxUv | input | 2 | Per slot: auxiliary input undervoltage |
| overTemp | input | 2 | Per slot: over-temperature |
| onN | input | 2 | Per slot: main enable, active low |
| auxEnN | input | 2 | Per slot: auxiliary enable, active low |
| forceOnN | input | 2 | Per slot: diagnostic override, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational |
| mainEn | output | 2 | Per slot: main switch enable |
| auxEn | output | 2 | Per slot: auxiliary switch enable |
| faultN | output | 2 | Per slot: fault, active low |
| pwrGdN | output | 2 | Per slot: power good, active low |
| intN | output | 1 | Shared interrupt, active low |

## Verification
The bench builds the block with `PorCycles` set to 20. This allows the bench to observe the end of the power-on hold and a later restart after a standby drop within a few dozen cycles. The regulation duration is programmed to 3 through its register. With that value the bench can interrupt an overload one cycle short of the trip, then confirm that a fresh run of exactly four samples trips the rail. Two slots are instanced, so the bench can test that the override on one slot and the faults on the other stay separate.

// File: rtl/hps_pkg.sv
package hps_pkg;
  localparam int NUM_SLOTS = 2;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int DUR_W     = 8;
  localparam int CTRL_W    = 3 * NUM_SLOTS + 1;
  localparam int STAT_W    = 3 * NUM_SLOTS;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LIVE = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DUR  = 2'd3;

  typedef logic [NUM_SLOTS-1:0] slotVec_t;

  // control register: intMask is the top bit, mainReg the lowest field
  typedef struct packed {
    logic     intMask;
    slotVec_t forceDis;
    slotVec_t auxReg;
    slotVec_t mainReg;
  } ctrlReg_t;

  typedef struct packed {
    slotVec_t ot;
    slotVec_t uv;
    slotVec_t oc;
  } statReg_t;

  // strobes from the control path into the register/latch datapath
  typedef struct packed {
    slotVec_t setOc;
    slotVec_t setUv;
    slotVec_t setOt;
    slotVec_t setMainLatch;
    slotVec_t setAuxLatch;
    slotVec_t clrMainLatch;
    slotVec_t clrAuxLatch;
  } strobe_t;
endpackage

// File: rtl/hps_ctrl.sv
module hps_ctrl import hps_pkg::*; #(
  parameter int PorCycles = 1000
) (
  input  logic             clk,
  input  logic             standbyOk,
  input  slotVec_t         senseRegHit,
  input  slotVec_t         senseShortHit,
  input  slotVec_t         mainUv,
  input  slotVec_t         auxUv,
  input  slotVec_t         overTemp,
  input  slotVec_t         onN,
  input  slotVec_t         auxEnN,
  input  slotVec_t         forceOnN,
  input  ctrlReg_t         ctrl,
  input  logic [DUR_W-1:0] regDur,
  input  slotVec_t         mainLatch,
  input  slotVec_t         auxLatch,
  output logic             porDone,
  output slotVec_t         mainEn,
  output slotVec_t         auxEn,
  output slotVec_t         faultN,
  output slotVec_t         pwrGdN,
  output slotVec_t         forceAct,
  output strobe_t          strobe
);
  localparam int PorW = $clog2(PorCycles + 1);

  logic [PorW-1:0] porCnt;

  always_ff @(posedge clk or negedge standbyOk) begin
    if (!standbyOk) begin
      porCnt  <= '0;
      porDone <= 1'b0;
    end else if (!porDone) begin
      if (porCnt == PorW'(PorCycles - 1)) porDone <= 1'b1;
      else porCnt <= porCnt + 1'b1;
    end
  end

  slotVec_t mainReq, auxReq, ocEv, uvEv, otEv;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [DUR_W-1:0] durCnt;
    logic             regActive;
    logic             timeout;

    assign mainReq[s]  = porDone & (~onN[s] | ctrl.mainReg[s]);
    assign auxReq[s]   = porDone & (~auxEnN[s] | ctrl.auxReg[s]);
    assign forceAct[s] = porDone & ~forceOnN[s] & ~ctrl.forceDis[s];

    assign mainEn[s] = forceAct[s] | (mainReq[s] & ~mainLatch[s] & ~mainUv[s]);
    assign auxEn[s]  = ~auxUv[s] & (forceAct[s] | (auxReq[s] & ~auxLatch[s]));
    assign faultN[s] = forceAct[s] | ~(mainLatch[s] | auxLatch[s]);
    assign pwrGdN[s] = forceAct[s] | ~(mainEn[s] & ~mainUv[s]);

    assign regActive = senseRegHit[s] & mainEn[s];
    assign timeout   = regActive & (durCnt == regDur);

    always_ff @(posedge clk or negedge standbyOk) begin
      if (!standbyOk)           durCnt <= '0;
      else if (!regActive)      durCnt <= '0;
      else if (durCnt != regDur) durCnt <= durCnt + 1'b1;
    end

    assign ocEv[s] = timeout | (senseShortHit[s] & mainEn[s]);
    assign uvEv[s] = mainUv[s] & mainReq[s];
    assign otEv[s] = overTemp[s] & auxEn[s];
  end

  assign strobe.setOc        = ocEv;
  assign strobe.setUv        = uvEv;
  assign strobe.setOt        = otEv;
  assign strobe.setMainLatch = (ocEv | uvEv) & ~forceAct;
  assign strobe.setAuxLatch  = otEv & ~forceAct;
  assign strobe.clrMainLatch = ~mainReq;
  assign strobe.clrAuxLatch  = ~auxReq;
endmodule

// File: rtl/hps_dp.sv
module hps_dp import hps_pkg::*; (
  input  logic              clk,
  input  logic              standbyOk,
  input  logic              porDone,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  strobe_t           strobe,
  input  slotVec_t          mainEn,
  input  slotVec_t          auxEn,
  output ctrlReg_t          ctrl,
  output logic [DUR_W-1:0]  regDur,
  output statReg_t          stat,
  output slotVec_t          mainLatch,
  output slotVec_t          auxLatch,
  output logic [DATA_W-1:0] rdData,
  output logic              intN
);
  logic [STAT_W-1:0] statClr;
  statReg_t          statSet;

  assign statClr = (wrEn && addr == ADDR_STAT) ? wrData[STAT_W-1:0] : '0;
  assign statSet = '{ot: strobe.setOt, uv: strobe.setUv, oc: strobe.setOc};

  always_ff @(posedge clk or negedge standbyOk) begin
    if (!standbyOk) begin
      ctrl      <= '0;
      regDur    <= '0;
      stat      <= '0;
      mainLatch <= '0;
      auxLatch  <= '0;
    end else if (!porDone) begin
      ctrl      <= '0;
      regDur    <= '0;
      stat      <= '0;
      mainLatch <= '0;
      auxLatch  <= '0;
    end else begin
      if (wrEn && addr == ADDR_CTRL) ctrl <= ctrlReg_t'(wrData[CTRL_W-1:0]);
      if (wrEn && addr == ADDR_DUR)  regDur <= wrData[DUR_W-1:0];
      stat      <= (stat & ~statClr) | statSet;
      mainLatch <= (mainLatch & ~strobe.clrMainLatch) | strobe.setMainLatch;
      auxLatch  <= (auxLatch & ~strobe.clrAuxLatch) | strobe.setAuxLatch;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = DATA_W'(ctrl);
      ADDR_STAT: rdData = DATA_W'(stat);
      ADDR_LIVE: rdData = DATA_W'({auxEn, mainEn});
      default:   rdData = DATA_W'(regDur);
    endcase
  end

  assign intN = ~(porDone & (|stat) & ~ctrl.intMask);
endmodule

// File: rtl/hotplug_supervisor.sv
module hotplug_supervisor import hps_pkg::*; #(
  parameter int PorCycles = 1000
) (
  input  logic                 clk,
  input  logic                 standbyOk,
  input  logic [NUM_SLOTS-1:0] senseRegHit,
  input  logic [NUM_SLOTS-1:0] senseShortHit,
  input  logic [NUM_SLOTS-1:0] mainUv,
  input  logic [NUM_SLOTS-1:0] auxUv,
  input  logic [NUM_SLOTS-1:0] overTemp,
  input  logic [NUM_SLOTS-1:0] onN,
  input  logic [NUM_SLOTS-1:0] auxEnN,
  input  logic [NUM_SLOTS-1:0] forceOnN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic [NUM_SLOTS-1:0] mainEn,
  output logic [NUM_SLOTS-1:0] auxEn,
  output logic [NUM_SLOTS-1:0] faultN,
  output logic [NUM_SLOTS-1:0] pwrGdN,
  output logic                 intN
);
  logic             porDone;
  slotVec_t         forceAct, mainLatch, auxLatch;
  ctrlReg_t         ctrl;
  statReg_t         statBits;
  logic [DUR_W-1:0] regDur;
  strobe_t          strobe;

  hps_ctrl #(.PorCycles(PorCycles)) i_ctrl (
    .clk(clk), .standbyOk(standbyOk),
    .senseRegHit(senseRegHit), .senseShortHit(senseShortHit),
    .mainUv(mainUv), .auxUv(auxUv), .overTemp(overTemp),
    .onN(onN), .auxEnN(auxEnN), .forceOnN(forceOnN),
    .ctrl(ctrl), .regDur(regDur), .mainLatch(mainLatch), .auxLatch(auxLatch),
    .porDone(porDone), .mainEn(mainEn), .auxEn(auxEn), .faultN(faultN),
    .pwrGdN(pwrGdN), .forceAct(forceAct), .strobe(strobe)
  );

  hps_dp i_dp (
    .clk(clk), .standbyOk(standbyOk), .porDone(porDone),
    .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .strobe(strobe), .mainEn(mainEn), .auxEn(auxEn),
    .ctrl(ctrl), .regDur(regDur), .stat(statBits),
    .mainLatch(mainLatch), .auxLatch(auxLatch),
    .rdData(regRdData), .intN(intN)
  );
endmodule

// File: rtl/hps_checker.sv
module hps_checker import hps_pkg::*; (
  input logic     clk,
  input logic     standbyOk,
  input logic     porDone,
  input logic     regWrEn,
  input slotVec_t mainEn,
  input slotVec_t auxEn,
  input slotVec_t faultN,
  input slotVec_t pwrGdN,
  input logic     intN,
  input slotVec_t senseShortHit,
  input slotVec_t auxUv,
  input slotVec_t forceAct,
  input statReg_t statBits
);
  // R1: nothing switches on before the power-on timer ends
  assert_por_off_R1: assert property (@(posedge clk) disable iff (!standbyOk)
    !porDone |-> (mainEn == '0 && auxEn == '0 && intN));

  // R12: interrupt only with a pending status bit
  assert_int_source_R12: assert property (@(posedge clk) disable iff (!standbyOk)
    !intN |-> (statBits != '0));

  // R11: a sticky bit only drops after a register write
  assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!standbyOk)
    ((($past(statBits) & ~statBits) != '0) && porDone && $past(porDone)) |-> $past(regWrEn));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    // R4: a hard short turns the main rail off at the next edge
    assert_short_off_R4: assert property (@(posedge clk) disable iff (!standbyOk)
      (senseShortHit[s] && mainEn[s] && !forceAct[s]) |=> (!mainEn[s] || forceAct[s]));

    // R8: aux undervoltage always wins, override included
    assert_aux_uv_R8: assert property (@(posedge clk) disable iff (!standbyOk)
      auxUv[s] |-> !auxEn[s]);

    // R9: override drives main on and releases fault and power-good
    assert_force_release_R9: assert property (@(posedge clk) disable iff (!standbyOk)
      forceAct[s] |-> (mainEn[s] && faultN[s] && pwrGdN[s]));
  end
endmodule

bind hotplug_supervisor hps_checker i_hps_checker (
  .clk(clk), .standbyOk(standbyOk), .porDone(porDone), .regWrEn(regWrEn),
  .mainEn(mainEn), .auxEn(auxEn), .faultN(faultN), .pwrGdN(pwrGdN), .intN(intN),
  .senseShortHit(senseShortHit), .auxUv(auxUv), .forceAct(forceAct),
  .statBits(statBits)
);

// File: tb/test_hotplug_supervisor.sv
module test_hotplug_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int POR = 20;

  logic       clk = 1'b0;
  logic       standbyOk = 1'b1;
  logic [1:0] senseRegHit = '0, senseShortHit = '0, mainUv = '0, auxUv = '0, overTemp = '0;
  logic [1:0] onN = 2'b11, auxEnN = 2'b11, forceOnN = 2'b11;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] mainEn, auxEn, faultN, pwrGdN;
  logic       intN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hotplug_supervisor #(.PorCycles(POR)) i_hotplug_supervisor (
    .clk(clk), .standbyOk(standbyOk), .senseRegHit(senseRegHit),
    .senseShortHit(senseShortHit), .mainUv(mainUv), .auxUv(auxUv),
    .overTemp(overTemp), .onN(onN), .auxEnN(auxEnN), .forceOnN(forceOnN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .mainEn(mainEn), .auxEn(auxEn), .faultN(faultN),
    .pwrGdN(pwrGdN), .intN(intN)
  );

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       mPor;
  int       mPorCnt;
  bit [6:0] mCtrl;
  bit [5:0] mStat;
  int       mDur;
  bit [1:0] mML, mAL;
  int       mRun [2];
  bit [1:0] eMain, eAux, eFault, ePg, eForce, eMReq, eAReq;
  bit       eInt;
  bit [7:0] eRd;

  function automatic void calcExp();
    for (int s = 0; s < 2; s++) begin
      eMReq[s]  = mPor && (!onN[s] || mCtrl[s]);
      eAReq[s]  = mPor && (!auxEnN[s] || mCtrl[2+s]);
      eForce[s] = mPor && !forceOnN[s] && !mCtrl[4+s];
      if (eForce[s]) begin
        eMain[s] = 1'b1; eAux[s] = !auxUv[s]; eFault[s] = 1'b1; ePg[s] = 1'b1;
      end else begin
        eMain[s]  = eMReq[s] && !mML[s] && !mainUv[s];
        eAux[s]   = eAReq[s] && !mAL[s] && !auxUv[s];
        eFault[s] = !(mML[s] || mAL[s]);
        ePg[s]    = !(eMain[s] && !mainUv[s]);
      end
    end
    eInt = !(mPor && mStat != 0 && !mCtrl[6]);
    case (regAddr)
      2'd0: eRd = {1'b0, mCtrl};
      2'd1: eRd = {2'b00, mStat};
      2'd2: eRd = {4'b0, eAux, eMain};
      default: eRd = mDur[7:0];
    endcase
  endfunction

  always @(posedge clk or negedge standbyOk) begin
    if (!standbyOk) begin
      mPor = 0; mPorCnt = 0; mCtrl = 0; mStat = 0; mDur = 0; mML = 0; mAL = 0;
      mRun[0] = 0; mRun[1] = 0;
    end else begin
      calcExp();
      if (!mPor) begin
        mPorCnt++;
        if (mPorCnt == POR) mPor = 1;
      end else begin
        bit [5:0] setBits = '0;
        bit [1:0] nML = mML, nAL = mAL;
        for (int s = 0; s < 2; s++) begin
          bit oc, uv, ot;
          oc = (senseRegHit[s] && eMain[s] && mRun[s] >= mDur) || (senseShortHit[s] && eMain[s]);
          uv = mainUv[s] && eMReq[s];
          ot = overTemp[s] && eAux[s];
          mRun[s] = (senseRegHit[s] && eMain[s]) ? mRun[s] + 1 : 0;
          setBits[s] = oc; setBits[2+s] = uv; setBits[4+s] = ot;
          if (!eMReq[s]) nML[s] = 0;
          if (!eAReq[s]) nAL[s] = 0;
          if ((oc || uv) && !eForce[s]) nML[s] = 1;
          if (ot && !eForce[s]) nAL[s] = 1;
        end
        if (regWrEn && regAddr == 2'd1) mStat = mStat & ~regWrData[5:0];
        mStat = mStat | setBits;
        if (regWrEn && regAddr == 2'd0) mCtrl = regWrData[6:0];
        if (regWrEn && regAddr == 2'd3) mDur = regWrData;
        mML = nML; mAL = nAL;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      calcExp();
      cmp("R2",  "model mainEn",  mainEn, eMain);
      cmp("R8",  "model auxEn",   auxEn,  eAux);
      cmp("R7",  "model faultN",  faultN, eFault);
      cmp("R2",  "model pwrGdN",  pwrGdN, ePg);
      cmp("R12", "model intN",    intN,   eInt);
      cmp("R13", "model rdData",  regRdData, eRd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick(1);
    regWrEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 standbyOk = 1'b0;
    tick(3);
    standbyOk = 1'b1;
    onN[0] = 1'b0;
    wrReg(2'd0, 8'h7F);
    tick(3);
    @(negedge clk);
    cmp("R1", "mainEn during POR", mainEn, 0);
    cmp("R1", "faultN during POR", faultN, 2'b11);
    regAddr = 2'd0;
    tick(POR);
    @(negedge clk);
    cmp("R1", "ctrl write ignored in POR", regRdData, 0);
    cmp("R2", "mainEn slot0 on", mainEn, 2'b01);
    cmp("R2", "pwrGdN slot0 low", pwrGdN, 2'b10);
    regAddr = 2'd2;
    @(negedge clk);
    cmp("R13", "live read", regRdData, 8'h01);

    // R3: regulation duration 3, interrupted run then full run
    tick(1);
    wrReg(2'd3, 8'd3);
    regAddr = 2'd3;
    @(negedge clk);
    cmp("R13", "duration readback", regRdData, 3);
    tick(1);
    senseRegHit[0] = 1'b1;
    tick(3);
    senseRegHit[0] = 1'b0;
    @(negedge clk);
    cmp("R3", "no trip after 3 samples", mainEn[0], 1);
    tick(1);
    senseRegHit[0] = 1'b1;
    tick(3);
    @(negedge clk);
    cmp("R3", "still on after 3 fresh samples", mainEn[0], 1);
    tick(1);
    @(negedge clk);
    cmp("R3", "trip on 4th sample", mainEn[0], 0);
    cmp("R7", "fault low after trip", faultN[0], 0);
    cmp("R12", "interrupt asserted", intN, 0);
    regAddr = 2'd1;
    @(negedge clk);
    cmp("R11", "oc sticky bit0", regRdData, 8'h01);
    tick(1);
    senseRegHit[0] = 1'b0;
    wrReg(2'd1, 8'h01);
    regAddr = 2'd1;
    @(negedge clk);
    cmp("R11", "oc cleared by write", regRdData, 0);
    cmp("R12", "interrupt released", intN, 1);
    cmp("R7", "fault still latched", faultN[0], 0);
    tick(1);
    onN[0] = 1'b1;
    tick(1);
    @(negedge clk);
    cmp("R7", "main fault cleared on release", faultN[0], 1);

    // R4: hard short
    tick(1);
    onN[0] = 1'b0;
    tick(1);
    senseShortHit[0] = 1'b1;
    tick(1);
    @(negedge clk);
    cmp("R4", "short trips main", mainEn[0], 0);
    tick(1);
    senseShortHit[0] = 1'b0;
    onN[0] = 1'b1;
    wrReg(2'd1, 8'h3F);

    // R5: undervoltage on register-enabled slot 1
    wrReg(2'd0, 8'h02);
    @(negedge clk);
    cmp("R2", "register enable slot1", mainEn[1], 1);
    tick(1);
    mainUv[1] = 1'b1;
    tick(1);
    mainUv[1] = 1'b0;
    regAddr = 2'd1;
    @(negedge clk);
    cmp("R5", "uv latched, main stays off", mainEn[1], 0);
    cmp("R5", "uv sticky bit3", regRdData, 8'h08);
    tick(1);
    wrReg(2'd0, 8'h00);
    tick(1);
    @(negedge clk);
    cmp("R7", "slot1 fault cleared", faultN[1], 1);

    // R6/R8/R7: aux independent of main uv, both rails faulted
    tick(1);
    wrReg(2'd1, 8'h3F);
    onN[0] = 1'b0; auxEnN[0] = 1'b0; mainUv[0] = 1'b1;
    tick(1);
    @(negedge clk);
    cmp("R8", "aux on despite main uv", auxEn[0], 1);
    tick(1);
    overTemp[0] = 1'b1;
    tick(1);
    @(negedge clk);
    cmp("R6", "over-temp turns aux off", auxEn[0], 0);
    tick(1);
    overTemp[0] = 1'b0; mainUv[0] = 1'b0; onN[0] = 1'b1;
    tick(1);
    @(negedge clk);
    cmp("R7", "aux fault keeps fault low", faultN[0], 0);
    tick(1);
    auxEnN[0] = 1'b1;
    tick(1);
    @(negedge clk);
    cmp("R7", "both released clears fault", faultN[0], 1);

    // R9: override on slot 1
    tick(1);
    wrReg(2'd1, 8'h3F);
    forceOnN[1] = 1'b0;
    @(negedge clk);
    cmp("R9", "force main on", mainEn[1], 1);
    cmp("R9", "force aux on", auxEn[1], 1);
    tick(1);
    senseShortHit[1] = 1'b1;
    tick(1);
    regAddr = 2'd1;
    @(negedge clk);
    cmp("R9", "main stays on under short", mainEn[1], 1);
    cmp("R9", "fault released under force", faultN[1], 1);
    cmp("R9", "status shows short", regRdData[1], 1);
    tick(1);
    senseShortHit[1] = 1'b0;
    auxUv[1] = 1'b1;
    @(negedge clk);
    cmp("R9", "aux uv not bypassed", auxEn[1], 0);
    tick(1);
    auxUv[1] = 1'b0;

    // R10: disable the override
    wrReg(2'd0, 8'h20);
    @(negedge clk);
    cmp("R10", "force disabled", mainEn[1], 0);

    // R12: interrupt mask
    tick(1);
    wrReg(2'd0, 8'h60);
    @(negedge clk);
    cmp("R12", "masked interrupt", intN, 1);
    tick(1);
    wrReg(2'd0, 8'h20);
    @(negedge clk);
    cmp("R12", "unmasked interrupt", intN, 0);

    // R1: standby drop restarts the timer
    tick(1);
    standbyOk = 1'b0;
    regAddr = 2'd0;
    @(negedge clk);
    cmp("R1", "outputs off on standby drop", {mainEn, auxEn}, 0);
    cmp("R1", "registers cleared", regRdData, 0);
    tick(2);
    standbyOk = 1'b1;
    tick(5);
    @(negedge clk);
    cmp("R1", "force held off during POR", mainEn[1], 0);
    tick(POR);
    @(negedge clk);
    cmp("R9", "force after POR", mainEn[1], 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule